// File: doc/BRIEF.md
# Write-Once Retriggerable Watchdog Timer

This block is a watchdog timer behind a one-register bus port. Software writes a single control word at offset 0 to configure and start it. That first write fixes four settings until the next system reset: the 12-bit reload value, the prescale select, the enable bit and a 2-bit select field. Every later write to the same offset is a kick. Its data is ignored, and it only reloads the down-counter from the stored reload value.

The counter is driven by a watchdog tick that runs at half the bus clock rate. When the prescale select is set, that tick is divided again by 16384. When the count runs out, the block raises an interrupt and a reset-request output together. Both outputs stay high until the next reset. Whether the reset request really resets the device is decided outside the block.

Reading offset 0 returns the locked settings in bits 15:0 and the live count in bits 27:16. This lets software watch the countdown.

The block has three state machines:
- Configuration machine (in `wdog_regif`). States are `CFG_OPEN` and `CFG_LOCKED`. The transition *configure* goes from `CFG_OPEN` to `CFG_LOCKED` on the first write to offset 0. The transition *kick* stays in `CFG_LOCKED` on each later write.
- Counter machine (in `wdog_count`). States are `RUN_IDLE`, `RUN_COUNT` and `RUN_EXPIRED`.
  - *start*: `RUN_IDLE` to `RUN_COUNT`, on a load that has the enable bit set.
  - *reload*: `RUN_COUNT` to `RUN_COUNT`, on a kick.
  - *expire*: `RUN_COUNT` to `RUN_EXPIRED`, on a tick that finds the count at 1 or 0.
  - `RUN_EXPIRED` is terminal until reset.

Top module: `wdog_lockkick`

## Requirements
- R1: After reset, `irq` and `rst_req` are 0, a read of offset 0 returns 0, and the counter does not run until offset 0 is written.
- R2: The first write to offset 0 latches four fields: reload value from bits 11:0, prescale select from bit 12, enable from bit 13, and select from bits 15:14. A read of offset 0 returns these fields in bits 15:0, the current count in bits 27:16, and 0 in bits 31:28.
- R3: No write after the first one changes any stored setting, whatever its data.
- R4: Every write to offset 0 loads the count with the stored reload value and restarts the tick dividers. For the first write, the stored value is the value just written.
- R5: With prescale off, the count drops by one every 2 clock cycles. The first decrement comes 2 cycles after the load.
- R6: With prescale on, the count drops by one every 32768 clock cycles (2 × 16384) after the load.
- R7: Take a reload value N ≥ 1 and a tick period P. Both `irq` and `rst_req` rise together right after clock edge N·P, counted from the last load edge. A reload value of 0 expires at the first tick. While expired, the count reads 0.
- R8: Once raised, `irq` and `rst_req` stay high until reset. Kicks after expiry change neither the outputs nor the count.
- R9: If the enable bit is 0 in the first write, the counter never runs and never expires, and later writes cannot enable it.
- R10: Writes to any offset other than 0 have no effect. Reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Expiry interrupt, sticky |
| rst_req | output | 1 | Expiry reset request, sticky |

## Verification
The bench checks the exact expiry edge, one cycle early and at the edge, for four cases: a small reload value, reload 0, the full 4095 reload, and a prescaled reload. A divider that is off by one, or that does not restart on a kick, fails one of these two samples.

It writes a second control word with every field different and checks that the readback keeps the first settings while the count reloads. A design that does not lock would show the new fields, or would stop counting because the enable bit was cleared.

Further scenarios cover three more faults:
- Kicks spaced just inside the timeout, followed by silence. This catches a design that misses kicks.
- Kicks after expiry. This catches outputs that are not sticky.
- A write to another offset before configuration. This catches a decoder that lets that write configure or lock the block.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int WD_CNT_W    = 12;
    localparam int WD_DATA_W   = 32;
    localparam int WD_ADDR_W   = 4;
    localparam int WD_PRESCALE = 16384;

    typedef enum logic {
        CFG_OPEN,
        CFG_LOCKED
    } cfg_state_e;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_COUNT,
        RUN_EXPIRED
    } run_state_e;
endpackage

// File: rtl/wdog_tick.sv
// Tick generator: half-rate stage followed by an optional prescaler.
// Both stages clear on restart so the first tick lands at a fixed
// distance from the load edge.
module wdog_tick #(
    parameter int PRESCALE = wdog_pkg::WD_PRESCALE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic pre_sel,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic half_q;
    logic pre_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (restart) begin
            half_q <= 1'b0;
        end else if (run) begin
            half_q <= ~half_q;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_cnt <= '0;
                end else if (restart) begin
                    pre_cnt <= '0;
                end else if (run && half_q && pre_sel) begin
                    if (pre_cnt == PRE_LAST) begin
                        pre_cnt <= '0;
                    end else begin
                        pre_cnt <= pre_cnt + 1'b1;
                    end
                end
            end

            assign pre_done = (pre_cnt == PRE_LAST);
        end else begin : g_nopre
            assign pre_done = 1'b1;
        end
    endgenerate

    assign tick = run && !restart && half_q && (!pre_sel || pre_done);
endmodule

// File: rtl/wdog_count.sv
// Down-counter with its run/expiry state machine and sticky outputs.
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_en,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             irq,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_e state_q;
    run_state_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE: begin
                if (load && load_en) begin
                    state_d = RUN_COUNT;           // start
                end
            end
            RUN_COUNT: begin
                if (load) begin
                    state_d = RUN_COUNT;           // reload
                end else if (tick && (cnt <= ONE)) begin
                    state_d = RUN_EXPIRED;         // expire
                end
            end
            RUN_EXPIRED: begin
                state_d = RUN_EXPIRED;
            end
            default: begin
                state_d = RUN_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RUN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Count register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_q != RUN_EXPIRED) begin
            if (load) begin
                cnt <= load_val;
            end else if ((state_q == RUN_COUNT) && tick) begin
                cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
            end
        end
    end

    // Output register: both expiry outputs follow the expired state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq     <= (state_d == RUN_EXPIRED);
            rst_req <= (state_d == RUN_EXPIRED);
        end
    end

    assign running = (state_q == RUN_COUNT);
endmodule

// File: rtl/wdog_regif.sv
// Register port: one control word at offset 0, locked after its first write.
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int CNT_W  = WD_CNT_W,
    parameter int DATA_W = WD_DATA_W,
    parameter int ADDR_W = WD_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_en,
    output logic              cfg_pre,
    output logic              cfg_en,
    output logic              cfg_locked,
    output logic [CNT_W+3:0]  cfg_word
);
    localparam int PRE_POS = CNT_W;
    localparam int EN_POS  = CNT_W + 1;
    localparam int SEL_POS = CNT_W + 2;
    localparam int CFG_W   = CNT_W + 4;
    localparam int PAD_W   = DATA_W - CFG_W - CNT_W;

    cfg_state_e       state_q;
    cfg_state_e       state_d;
    logic [CNT_W-1:0] cfg_reload;
    logic [1:0]       cfg_sel;
    logic             hit;
    logic             wr_hit;
    logic             unused_wdata_hi;

    assign hit             = bus_sel && (bus_addr == '0);
    assign wr_hit          = hit && bus_wr;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN: begin
                if (wr_hit) begin
                    state_d = CFG_LOCKED;          // configure
                end
            end
            CFG_LOCKED: begin
                state_d = CFG_LOCKED;              // kick or idle
            end
            default: begin
                state_d = CFG_OPEN;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Settings are captured only on the configure transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_reload <= '0;
            cfg_pre    <= 1'b0;
            cfg_en     <= 1'b0;
            cfg_sel    <= 2'b00;
        end else if ((state_q == CFG_OPEN) && wr_hit) begin
            cfg_reload <= bus_wdata[CNT_W-1:0];
            cfg_pre    <= bus_wdata[PRE_POS];
            cfg_en     <= bus_wdata[EN_POS];
            cfg_sel    <= bus_wdata[SEL_POS +: 2];
        end
    end

    assign cfg_locked = (state_q == CFG_LOCKED);
    assign load       = wr_hit;
    assign load_val   = cfg_locked ? cfg_reload : bus_wdata[CNT_W-1:0];
    assign load_en    = cfg_locked ? cfg_en     : bus_wdata[EN_POS];
    assign cfg_word   = {cfg_sel, cfg_en, cfg_pre, cfg_reload};
    assign bus_rdata  = (hit && !bus_wr) ? {{PAD_W{1'b0}}, cnt_val, cfg_word} : '0;
endmodule

// File: rtl/wdog_lockkick.sv
// Top: write-once, kick-to-reload watchdog timer.
module wdog_lockkick
    import wdog_pkg::*;
#(
    parameter int CNT_W    = WD_CNT_W,
    parameter int DATA_W   = WD_DATA_W,
    parameter int ADDR_W   = WD_ADDR_W,
    parameter int PRESCALE = WD_PRESCALE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam int CFG_W = CNT_W + 4;

    logic             kick;
    logic [CNT_W-1:0] load_val;
    logic             load_en;
    logic             cfg_pre;
    logic             cfg_en;
    logic             cfg_locked;
    logic [CFG_W-1:0] cfg_word;
    logic [CNT_W-1:0] cnt_val;
    logic             running;
    logic             tick;

    wdog_regif #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_val),
        .bus_rdata (bus_rdata),
        .load      (kick),
        .load_val  (load_val),
        .load_en   (load_en),
        .cfg_pre   (cfg_pre),
        .cfg_en    (cfg_en),
        .cfg_locked(cfg_locked),
        .cfg_word  (cfg_word)
    );

    wdog_tick #(
        .PRESCALE(PRESCALE)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(kick),
        .run    (running),
        .pre_sel(cfg_pre),
        .tick   (tick)
    );

    wdog_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (kick),
        .load_val(load_val),
        .load_en (load_en),
        .tick    (tick),
        .cnt     (cnt_val),
        .running (running),
        .irq     (irq),
        .rst_req (rst_req)
    );
endmodule

// File: rtl/wdog_lockkick_chk.sv
module wdog_lockkick_chk #(
    parameter int CNT_W = wdog_pkg::WD_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             rst_req,
    input logic             cfg_locked,
    input logic             cfg_en,
    input logic             kick,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W+3:0] cfg_word
);
    // R8
    sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);

    // R7
    irq_rst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rst_req);

    // R7
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt_val == '0));

    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> (cfg_locked && $stable(cfg_word)));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !irq);

    // R5
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kick |=> (cnt_val <= $past(cnt_val)));
endmodule

bind wdog_lockkick wdog_lockkick_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .rst_req   (rst_req),
    .cfg_locked(cfg_locked),
    .cfg_en    (cfg_en),
    .kick      (kick),
    .cnt_val   (cnt_val),
    .cfg_word  (cfg_word)
);

// File: tb/wdog_lockkick_test.sv
`timescale 1ns/1ps
module wdog_lockkick_test;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic              rst_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdog_lockkick uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // {select, enable, prescale, reload}
    function automatic logic [31:0] cfg(int rl, bit pre, bit en, int sel);
        return {16'h0, 2'(sel), en, pre, 12'(rl)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cy(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(string req, string what, bit exp);
        check(req, what, {30'h0, rst_req, irq}, exp ? 32'h3 : 32'h0);
    endtask

    task automatic t_reset_idle();
        logic [31:0] d;
        do_reset();
        check_out("R1", "outputs after reset", 1'b0);
        rd(0, d);
        check("R1", "readback after reset", d, 32'h0);
        wait_cy(100);
        check_out("R1", "no expiry before first write", 1'b0);
        rd(0, d);
        check("R1", "count idle before first write", d, 32'h0);
    endtask

    task automatic t_basic_sticky();
        logic [31:0] d;
        do_reset();
        wr(0, cfg(5, 0, 1, 2));
        rd(0, d);
        check("R2", "config and count after first write", d, 32'h0005_A005);
        wait_cy(2);
        rd(0, d);
        check("R5", "first decrement after 2 cycles", d, 32'h0004_A005);
        wait_cy(7);
        check_out("R7", "one cycle before expiry", 1'b0);
        wait_cy(1);
        check_out("R7", "at expiry edge", 1'b1);
        rd(0, d);
        check("R7", "count zero when expired", d, 32'h0000_A005);
        wr(0, 32'h0);
        wait_cy(20);
        check_out("R8", "sticky after kick", 1'b1);
        rd(0, d);
        check("R8", "kick after expiry leaves count", d, 32'h0000_A005);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(0, cfg(5, 0, 1, 2));
        wait_cy(3);
        rd(0, d);
        check("R5", "count after one tick", d, 32'h0004_A005);
        wr(0, 32'hFFFF_5FFF);
        rd(0, d);
        check("R3", "settings unchanged, count reloaded (R4)", d, 32'h0005_A005);
        wait_cy(9);
        check_out("R3", "still running with old period", 1'b0);
        wait_cy(1);
        check_out("R4", "expiry 10 cycles after kick", 1'b1);
    endtask

    task automatic t_kicks();
        do_reset();
        wr(0, cfg(5, 0, 1, 2));
        for (int i = 0; i < 10; i++) begin
            wait_cy(4);
            check_out("R4", "kicked in time", 1'b0);
            wr(0, 32'h1234_5678);
        end
        wait_cy(9);
        check_out("R4", "one cycle before expiry after last kick", 1'b0);
        wait_cy(1);
        check_out("R4", "expiry after last kick", 1'b1);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        do_reset();
        wr(0, cfg(3, 0, 0, 2));
        wait_cy(40);
        check_out("R9", "disabled never expires", 1'b0);
        rd(0, d);
        check("R9", "disabled count holds", d, 32'h0003_8003);
        wr(0, cfg(3, 0, 1, 2));
        rd(0, d);
        check("R9", "late enable ignored", d, 32'h0003_8003);
        wait_cy(40);
        check_out("R9", "still quiet after late enable", 1'b0);
    endtask

    task automatic t_zero();
        do_reset();
        wr(0, cfg(0, 0, 1, 2));
        wait_cy(1);
        check_out("R7", "reload 0 before first tick", 1'b0);
        wait_cy(1);
        check_out("R7", "reload 0 expires at first tick", 1'b1);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        do_reset();
        wr(0, cfg(1, 1, 1, 2));
        wait_cy(2);
        rd(0, d);
        check("R6", "no decrement at 2 cycles with prescale", d, 32'h0001_B001);
        wait_cy(32765);
        check_out("R6", "one cycle before prescaled expiry", 1'b0);
        wait_cy(1);
        check_out("R6", "prescaled expiry at 32768", 1'b1);
    endtask

    task automatic t_other_addr();
        logic [31:0] d;
        do_reset();
        wr(4, cfg(1, 0, 1, 2));
        rd(0, d);
        check("R10", "write elsewhere does not configure", d, 32'h0);
        rd(4, d);
        check("R10", "read elsewhere is zero", d, 32'h0);
        wait_cy(20);
        check_out("R10", "no counting after write elsewhere", 1'b0);
        wr(0, cfg(2, 0, 1, 2));
        rd(0, d);
        check("R10", "block still open after write elsewhere", d, 32'h0002_A002);
        wait_cy(3);
        check_out("R7", "reload 2 before expiry", 1'b0);
        wait_cy(1);
        check_out("R7", "reload 2 expiry", 1'b1);
    endtask

    task automatic t_max();
        logic [31:0] d;
        do_reset();
        wr(0, cfg(4095, 0, 1, 2));
        rd(0, d);
        check("R2", "full reload readback", d, 32'h0FFF_AFFF);
        wait_cy(8189);
        check_out("R7", "full reload one cycle early", 1'b0);
        wait_cy(1);
        check_out("R7", "full reload expiry", 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_basic_sticky();
        t_lock();
        t_kicks();
        t_disabled();
        t_zero();
        t_other_addr();
        t_max();
        t_prescale();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule